// File: doc/BRIEF.md
# Host Receive Path Lock Controller

This block keeps the host-to-core receive path reserved for a single external bus master at a time. Host writes land in a small receive FIFO, and the core drains that FIFO through a read port. When the interface runs in its bus-master-capable mode and the core has turned on lock protection, the end of a write burst arms a lock. Three kinds of burst end count: a plain write, the release of the bus lock line after an exclusive sequence, or the completion of a read that this interface started as master. While the lock is armed, every new host write is answered with retry.

Once the core has emptied the FIFO with the lock armed, a sticky transfer-complete flag is set. Host writes stay refused until the core writes one to that flag, which clears both the flag and the lock. In any other mode, or with protection off, a host write is refused only when the FIFO is full. The core may change the protection enable only while the interface is idle or the flag is set. A hardware reset or a software reset returns everything to the open state.

Top module: `rx_lock_ctrl`

## Requirements
- R1: When `mode_sel` differs from MASTER_MODE (default 1), the lock enable has no effect: a request offered while the FIFO has space is acknowledged, and `done_flag` never sets.
- R2: With protection active (lock enable is 1 and `mode_sel` equals MASTER_MODE), an accepted write with `host_lock` low arms the lock. Every later write is answered with `host_wr_retry`.
- R3: Accepted writes with `host_lock` high do not arm the lock. The lock arms at the first clock edge at which `host_lock` is low after such a write, so the next request is retried.
- R4: With protection active, a pulse on `mst_rd_done` arms the lock.
- R5: When the lock is armed and the FIFO level is 0 at a clock edge, `done_flag` is 1 after that edge. While `done_flag` is 1, all host writes are retried.
- R6: A core pulse on `done_clr` clears `done_flag` and the armed lock at the next edge. After that, writes are accepted again if the FIFO has space.
- R7: With lock enable at 0, `done_flag` never sets, and writes are refused only when the FIFO is full.
- R8: A request offered while the FIFO holds DEPTH (default 6) words is answered with retry and stores nothing, whatever the lock state.
- R9: A `cfg_wr` pulse loads `cfg_lock_en` into `lock_en` only when `iface_active` is 0 or `done_flag` is 1. At other times the pulse is ignored.
- R10: Both `rst` and `soft_rst` clear `lock_en`, the armed lock, `done_flag` and the FIFO, so that the first write afterwards is acknowledged.
- R11: The FIFO returns words in write order. A `core_rd` pulse on a non-empty FIFO places the oldest word on `core_rd_data` after the edge.
- R12: Each request gets exactly one of `host_wr_ack` or `host_wr_retry` in the cycle after it is offered. Neither is asserted without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| soft_rst | input | 1 | Synchronous software reset, active high |
| mode_sel | input | MODE_W | Interface mode; MASTER_MODE selects bus-master-capable operation |
| iface_active | input | 1 | Interface busy; blocks lock-enable changes unless `done_flag` is set |
| host_wr_req | input | 1 | Host offers one word |
| host_wr_data | input | DATA_W | Word offered by the host |
| host_lock | input | 1 | Bus lock line; high marks an exclusive sequence |
| mst_rd_done | input | 1 | Pulse: a read started by this interface as master has completed |
| core_rd | input | 1 | Core pops one word |
| core_rd_data | output | DATA_W | Word popped by the last core read (registered) |
| cfg_wr | input | 1 | Core writes the lock enable |
| cfg_lock_en | input | 1 | Value for the lock enable |
| done_clr | input | 1 | Core writes one to the transfer-complete flag |
| host_wr_ack | output | 1 | Previous-cycle request accepted |
| host_wr_retry | output | 1 | Previous-cycle request refused (retry) |
| lock_en | output | 1 | Current lock enable |
| done_flag | output | 1 | Sticky transfer-complete flag |
| rx_level | output | LVL_W | FIFO occupancy |
| rx_empty | output | 1 | FIFO empty |

## Verification
A wrong armed or exclusive-tracking state shows one cycle later, as an ack where a retry belongs or the other way round, on the first request after the burst end. A lost or spurious set of the completion flag shows on `done_flag` one edge after the FIFO drains. It also shows as refused or accepted writes until the core's write-one. FIFO pointer or level faults show as a wrong ack/retry at the DEPTH boundary, or as out-of-order words on `core_rd_data` right after each pop. Errors in lock-enable gating or reset show directly on `lock_en` one edge after the configuration write or reset.

// File: rtl/rx_lock_pkg.sv
package rx_lock_pkg;
  localparam int DEF_DATA_W = 24;
  localparam int DEF_DEPTH  = 6;
  localparam int DEF_MODE_W = 3;

  typedef enum logic [1:0] {
    RESP_NONE  = 2'b00,
    RESP_ACK   = 2'b01,
    RESP_RETRY = 2'b10
  } wr_resp_e;
endpackage

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              full
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;

  assign empty = (level == '0);
  assign full  = (level == FULL_LVL);

  // storage array without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (pop) pop_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rx_gate_ctrl.sv
module rx_gate_ctrl #(
  parameter int MODE_W      = 3,
  parameter int MASTER_MODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              iface_active,
  input  logic              wr_req,
  input  logic              host_lock,
  input  logic              mst_rd_done,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic              cfg_wr,
  input  logic              cfg_lock_en,
  input  logic              done_clr,
  output logic              wr_accept,
  output logic              lock_en,
  output logic              done_flag
);
  localparam logic [MODE_W-1:0] MM = MODE_W'(MASTER_MODE);

  logic armed, excl_seen, prot_on, refuse, arm_evt, done_set;

  assign prot_on  = lock_en && (mode_sel == MM);
  assign refuse   = soft_rst || fifo_full || done_flag || (prot_on && armed);
  assign wr_accept = wr_req && !refuse;
  assign arm_evt  = prot_on && ((wr_accept && !host_lock) ||
                                (excl_seen && !host_lock) || mst_rd_done);
  assign done_set = prot_on && armed && fifo_empty && !done_clr;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      lock_en   <= 1'b0;
      armed     <= 1'b0;
      excl_seen <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (cfg_wr && (!iface_active || done_flag)) lock_en <= cfg_lock_en;

      if (!prot_on)               excl_seen <= 1'b0;
      else if (wr_accept && host_lock) excl_seen <= 1'b1;
      else if (!host_lock)        excl_seen <= 1'b0;

      if (!prot_on || done_clr)   armed <= 1'b0;
      else if (arm_evt)           armed <= 1'b1;

      if (done_clr)               done_flag <= 1'b0;
      else if (done_set)          done_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_lock_ctrl.sv
module rx_lock_ctrl
  import rx_lock_pkg::*;
#(
  parameter int DATA_W      = DEF_DATA_W,
  parameter int DEPTH       = DEF_DEPTH,
  parameter int MODE_W      = DEF_MODE_W,
  parameter int MASTER_MODE = 1,
  localparam int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              iface_active,
  input  logic              host_wr_req,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_lock,
  input  logic              mst_rd_done,
  input  logic              core_rd,
  output logic [DATA_W-1:0] core_rd_data,
  input  logic              cfg_wr,
  input  logic              cfg_lock_en,
  input  logic              done_clr,
  output logic              host_wr_ack,
  output logic              host_wr_retry,
  output logic              lock_en,
  output logic              done_flag,
  output logic [LVL_W-1:0]  rx_level,
  output logic              rx_empty
);
  logic wr_accept, fifo_full, pop;
  wr_resp_e resp_q;

  assign pop = core_rd && !rx_empty && !soft_rst;

  rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(soft_rst),
    .push(wr_accept), .push_data(host_wr_data),
    .pop(pop), .pop_data(core_rd_data),
    .level(rx_level), .empty(rx_empty), .full(fifo_full)
  );

  rx_gate_ctrl #(.MODE_W(MODE_W), .MASTER_MODE(MASTER_MODE)) u_gate (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .mode_sel(mode_sel), .iface_active(iface_active),
    .wr_req(host_wr_req), .host_lock(host_lock), .mst_rd_done(mst_rd_done),
    .fifo_full(fifo_full), .fifo_empty(rx_empty),
    .cfg_wr(cfg_wr), .cfg_lock_en(cfg_lock_en), .done_clr(done_clr),
    .wr_accept(wr_accept), .lock_en(lock_en), .done_flag(done_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)              resp_q <= RESP_NONE;
    else if (!host_wr_req) resp_q <= RESP_NONE;
    else if (wr_accept)    resp_q <= RESP_ACK;
    else                   resp_q <= RESP_RETRY;
  end

  assign host_wr_ack   = (resp_q == RESP_ACK);
  assign host_wr_retry = (resp_q == RESP_RETRY);
endmodule

// File: rtl/rx_lock_ctrl_chk.sv
module rx_lock_ctrl_chk #(
  parameter int DEPTH       = 6,
  parameter int MODE_W      = 3,
  parameter int MASTER_MODE = 1,
  parameter int LVL_W       = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic [MODE_W-1:0] mode_sel,
  input logic              iface_active,
  input logic              host_wr_req,
  input logic              cfg_wr,
  input logic              done_clr,
  input logic              host_wr_ack,
  input logic              host_wr_retry,
  input logic              lock_en,
  input logic              done_flag,
  input logic [LVL_W-1:0]  rx_level
);
  assert_one_resp_R12: assert property (@(posedge clk) disable iff (rst)
    !(host_wr_ack && host_wr_retry));

  assert_resp_needs_req_R12: assert property (@(posedge clk) disable iff (rst)
    host_wr_req |=> (host_wr_ack || host_wr_retry));

  assert_full_retry_R8: assert property (@(posedge clk) disable iff (rst)
    (host_wr_req && rx_level == LVL_W'(DEPTH)) |=> (host_wr_retry && !host_wr_ack));

  assert_mode_ignore_R1: assert property (@(posedge clk) disable iff (rst)
    (host_wr_req && !soft_rst && !done_flag && mode_sel != MODE_W'(MASTER_MODE)
     && rx_level < LVL_W'(DEPTH)) |=> host_wr_ack);

  assert_done_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(lock_en && mode_sel == MODE_W'(MASTER_MODE)));

  assert_done_on_empty_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(rx_level == '0));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
    done_clr |=> !done_flag);

  assert_cfg_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && iface_active && !done_flag && !soft_rst) |=> $stable(lock_en));

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!lock_en && !done_flag && rx_level == '0));
endmodule

bind rx_lock_ctrl rx_lock_ctrl_chk #(
  .DEPTH(DEPTH), .MODE_W(MODE_W), .MASTER_MODE(MASTER_MODE), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .mode_sel(mode_sel),
  .iface_active(iface_active), .host_wr_req(host_wr_req), .cfg_wr(cfg_wr),
  .done_clr(done_clr), .host_wr_ack(host_wr_ack), .host_wr_retry(host_wr_retry),
  .lock_en(lock_en), .done_flag(done_flag), .rx_level(rx_level)
);

// File: tb/rx_lock_ctrl_tb.sv
module rx_lock_ctrl_tb;
  localparam int DATA_W = 24;
  localparam int DEPTH  = 6;
  localparam int MODE_W = 3;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst, soft_rst, iface_active, host_wr_req, host_lock, mst_rd_done;
  logic core_rd, cfg_wr, cfg_lock_en, done_clr;
  logic [MODE_W-1:0] mode_sel;
  logic [DATA_W-1:0] host_wr_data, core_rd_data;
  logic host_wr_ack, host_wr_retry, lock_en, done_flag, rx_empty;
  logic [LVL_W-1:0] rx_level;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_lock_ctrl u_dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .mode_sel(mode_sel),
    .iface_active(iface_active), .host_wr_req(host_wr_req),
    .host_wr_data(host_wr_data), .host_lock(host_lock), .mst_rd_done(mst_rd_done),
    .core_rd(core_rd), .core_rd_data(core_rd_data), .cfg_wr(cfg_wr),
    .cfg_lock_en(cfg_lock_en), .done_clr(done_clr), .host_wr_ack(host_wr_ack),
    .host_wr_retry(host_wr_retry), .lock_en(lock_en), .done_flag(done_flag),
    .rx_level(rx_level), .rx_empty(rx_empty)
  );

  // {wr, lock, rd, clr, mst_done, exp_ack, exp_retry, exp_done}
  localparam logic [7:0] VEC [17] = '{
    8'b10000_100, // R2 plain write accepted, arms
    8'b10000_010, // R2 next write retried
    8'b00100_000, // R5 core drains last word
    8'b00000_001, // R5 armed and empty -> done
    8'b10000_011, // R5 write refused while done
    8'b00010_000, // R6 write one clears
    8'b10000_100, // R6 accepted again, arms
    8'b00010_000, // R6 clear the armed lock
    8'b11000_100, // R3 exclusive word, no arm
    8'b11000_100, // R3 exclusive word, no arm
    8'b00000_000, // R3 lock released -> arm
    8'b10000_010, // R3 refused after release
    8'b00010_000, // R6 clear
    8'b00001_000, // R4 master read complete -> arm
    8'b10000_010, // R4 refused
    8'b00010_000, // R6 clear
    8'b10000_100  // R6 accepted
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    host_wr_req = 0; host_lock = 0; mst_rd_done = 0; core_rd = 0;
    cfg_wr = 0; done_clr = 0; soft_rst = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst = 1;
    @(negedge clk);
    rst = 0;
  endtask

  task automatic set_en(logic v);
    cfg_wr = 1; cfg_lock_en = v;
    cyc();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; mode_sel = 3'd1; iface_active = 0; cfg_lock_en = 0;
    host_wr_data = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    check("R10 reset lock_en", lock_en, 0);
    check("R10 reset done", done_flag, 0);
    check("R10 reset empty", rx_empty, 1);
    check("R12 no response idle", {host_wr_ack, host_wr_retry}, 0);

    set_en(1);
    check("R9 enable while idle", lock_en, 1);

    foreach (VEC[i]) begin
      host_wr_req = VEC[i][7]; host_lock = VEC[i][6]; core_rd = VEC[i][5];
      done_clr = VEC[i][4]; mst_rd_done = VEC[i][3];
      host_wr_data = 24'h100 + 24'(i);
      @(posedge clk);
      #1;
      check($sformatf("R12 table ack step %0d", i), host_wr_ack, VEC[i][2]);
      check($sformatf("R12 table retry step %0d", i), host_wr_retry, VEC[i][1]);
      check($sformatf("R5 table done step %0d", i), done_flag, VEC[i][0]);
      @(negedge clk);
      idle_inputs();
    end

    // R10 soft reset clears everything
    soft_rst = 1; cyc();
    check("R10 soft lock_en", lock_en, 0);
    check("R10 soft empty", rx_level, 0);
    host_wr_req = 1; cyc();
    check("R10 first write after soft reset", host_wr_ack, 1);

    // R8 and R11: fill in mode 0 with lock enabled, order check
    do_reset();
    set_en(1);
    mode_sel = 3'd0;
    for (int k = 0; k < DEPTH; k++) begin
      host_wr_req = 1; host_wr_data = 24'hA00 + 24'(k); cyc();
      check("R1 write accepted in other mode", host_wr_ack, 1);
    end
    host_wr_req = 1; host_wr_data = 24'hBAD; cyc();
    check("R8 full retry", host_wr_retry, 1);
    check("R8 level stays", rx_level, DEPTH);
    for (int k = 0; k < DEPTH; k++) begin
      core_rd = 1; cyc();
      check("R11 read order", core_rd_data, 24'hA00 + 24'(k));
    end
    cyc();
    check("R1 no done in other mode", done_flag, 0);

    // R7 protection off in master mode
    do_reset();
    mode_sel = 3'd1;
    host_wr_req = 1; cyc();
    host_wr_req = 1; cyc();
    check("R7 second write accepted", host_wr_ack, 1);
    core_rd = 1; cyc();
    core_rd = 1; cyc();
    cyc();
    check("R7 done never set", done_flag, 0);

    // R9 gating by activity and done
    do_reset();
    iface_active = 1;
    set_en(1);
    check("R9 ignored while active", lock_en, 0);
    iface_active = 0;
    set_en(1);
    host_wr_req = 1; cyc();
    core_rd = 1; cyc();
    cyc();
    check("R5 done after drain", done_flag, 1);
    iface_active = 1;
    set_en(0);
    check("R9 change allowed when done", lock_en, 0);
    iface_active = 0;

    // R10 hardware reset clears lock_en
    set_en(1);
    do_reset();
    check("R10 hw reset lock_en", lock_en, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule